// File: doc/BRIEF.md
# Activation and Iteration Tag Rewriter

This block sits at the boundaries of program regions and loops in a tagged-token dataflow fabric. Every token carries a tag with three fields: an activation identifier, a nesting depth and an iteration count. No other part of the fabric changes these fields. The data value rides along untouched. The block offers three independent token paths, and each has a valid/ready input and a registered valid/ready output.

The region path has two operations. Opening a region takes a spare activation identifier and records the arriving tag against it. The new tag carries the new identifier, a depth one greater than before, and an iteration count of zero. Closing a region looks up the recorded tag, puts it back on the token and hands the identifier back. The iteration path bumps the iteration count once for each trip around a loop. The loop-exit path restores the pre-loop tag in the same way as a region close. It also emits a one-cycle notice that names the activation being resumed and the identifier just freed, so the manager for the outer level learns of the return.

Activation 0 is the root context. It is never handed out and never released. Spare identifiers are the values 1 to 2^ACT_W−1, and the lowest free one is always taken first.

Top module: `ctx_tag_unit`

## Requirements
- R1: After reset all three output valids and the notice valid are low, and the region path is ready for an open request.
- R2: A token accepted on the iteration path appears one cycle later. Its iteration count is one greater, wrapping modulo 2^ITER_W. Its activation, depth and data are unchanged. Tags are packed as {activation[8:6], depth[5:4], iteration[3:0]}.
- R3: A region open (kind = 0) gives the token the lowest-numbered free activation, raises the depth by one and sets the iteration to zero. The data is unchanged.
- R4: A region close (kind = 1) on a non-root activation outputs the tag that was recorded when that activation was opened, and returns the identifier to the free pool.
- R5: A loop exit on a non-root activation outputs the recorded pre-loop tag. In the same cycle as that output first shows valid, the notice is valid for exactly one cycle and carries the resumed activation and the freed identifier.
- R6: While no identifier is free, the region path holds ready low for open requests. Ready returns as soon as an identifier is released.
- R7: An open request whose depth is already at its maximum value (3) is stalled with ready low and the error output high. No token is emitted for it.
- R8: A close or loop exit on activation 0 passes the tag through unchanged and releases nothing.
- R9: While an output is valid and its downstream ready is low, the output holds its tag and data, and the matching input ready is low.
- R10: Freed identifiers are reused, so the next open after a release can receive the identifier that was just freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_in_valid | input | 1 | Region-path request valid |
| ent_in_ready | output | 1 | Region-path request accepted |
| ent_in_kind | input | 1 | 0 = open region, 1 = close region |
| ent_in_tag | input | 9 | Incoming tag |
| ent_in_data | input | DATA_W | Incoming data |
| ent_out_valid | output | 1 | Region-path result valid |
| ent_out_ready | input | 1 | Downstream ready for region path |
| ent_out_tag | output | 9 | Rewritten tag |
| ent_out_data | output | DATA_W | Data, unchanged |
| ent_err | output | 1 | Open request stalled at maximum depth |
| it_in_valid | input | 1 | Iteration-path input valid |
| it_in_ready | output | 1 | Iteration-path input accepted |
| it_in_tag | input | 9 | Incoming tag |
| it_in_data | input | DATA_W | Incoming data |
| it_out_valid | output | 1 | Iteration-path result valid |
| it_out_ready | input | 1 | Downstream ready for iteration path |
| it_out_tag | output | 9 | Tag with iteration advanced |
| it_out_data | output | DATA_W | Data, unchanged |
| lx_in_valid | input | 1 | Loop-exit input valid |
| lx_in_ready | output | 1 | Loop-exit input accepted |
| lx_in_tag | input | 9 | Incoming tag |
| lx_in_data | input | DATA_W | Incoming data |
| lx_out_valid | output | 1 | Loop-exit result valid |
| lx_out_ready | input | 1 | Downstream ready for loop exit |
| lx_out_tag | output | 9 | Restored tag |
| lx_out_data | output | DATA_W | Data, unchanged |
| note_valid | output | 1 | One-cycle restoration notice |
| note_outer_act | output | 3 | Activation resumed after the loop |
| note_freed_act | output | 3 | Identifier returned to the pool |

## Verification
A fault in the free pool shows up at the very next open request. The identifier handed out will be wrong, or ready will drop while identifiers are still free. The bench therefore runs opens right after each release and right after the pool is drained.

A fault in the saved-tag table does not show when the region is opened. It shows only later, when that activation is closed or leaves its loop and the wrong prior tag comes back. For this reason each restore is compared against the tag that was recorded earlier.

A fault in the tag arithmetic appears one cycle after acceptance, on the registered output.

// File: rtl/ctx_tag_pkg.sv
package ctx_tag_pkg;

    localparam int ACT_W   = 3;
    localparam int NEST_W  = 2;
    localparam int ITER_W  = 4;
    localparam int NUM_ACT = 1 << ACT_W;
    localparam int TAG_W   = ACT_W + NEST_W + ITER_W;

    typedef struct packed {
        logic [ACT_W-1:0]  act;
        logic [NEST_W-1:0] nest;
        logic [ITER_W-1:0] iter;
    } tag_t;

    typedef enum logic {
        K_OPEN  = 1'b0,
        K_CLOSE = 1'b1
    } region_op_e;

    function automatic tag_t step_iter(tag_t t);
        tag_t r;
        r      = t;
        r.iter = t.iter + 1'b1;
        return r;
    endfunction

    function automatic tag_t open_ctx(tag_t t, logic [ACT_W-1:0] id);
        tag_t r;
        r.act  = id;
        r.nest = t.nest + 1'b1;
        r.iter = '0;
        return r;
    endfunction

    function automatic logic nest_full(tag_t t);
        return t.nest == {NEST_W{1'b1}};
    endfunction

endpackage

// File: rtl/ctx_out_reg.sv
module ctx_out_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] q,
    output logic         can_load
);
    assign can_load = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            q         <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            q         <= d;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ctx_free_pool.sv
module ctx_free_pool
    import ctx_tag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  tag_t             save_tag,
    output logic             avail,
    output logic [ACT_W-1:0] alloc_id,
    input  logic             rel_a,
    input  logic [ACT_W-1:0] rel_a_id,
    output tag_t             saved_a,
    input  logic             rel_b,
    input  logic [ACT_W-1:0] rel_b_id,
    output tag_t             saved_b
);
    logic [NUM_ACT-1:0] busy;
    tag_t               prior_tbl [NUM_ACT];

    // lowest free identifier, root (0) excluded
    always_comb begin
        avail    = 1'b0;
        alloc_id = '0;
        for (int i = NUM_ACT - 1; i >= 1; i--) begin
            if (!busy[i]) begin
                avail    = 1'b1;
                alloc_id = ACT_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= '0;
        end else begin
            if (alloc) busy[alloc_id] <= 1'b1;
            if (rel_a) busy[rel_a_id] <= 1'b0;
            if (rel_b) busy[rel_b_id] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc) prior_tbl[alloc_id] <= save_tag;
    end

    assign saved_a = prior_tbl[rel_a_id];
    assign saved_b = prior_tbl[rel_b_id];
endmodule

// File: rtl/ctx_tag_unit.sv
module ctx_tag_unit
    import ctx_tag_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ent_in_valid,
    output logic              ent_in_ready,
    input  logic              ent_in_kind,
    input  logic [TAG_W-1:0]  ent_in_tag,
    input  logic [DATA_W-1:0] ent_in_data,
    output logic              ent_out_valid,
    input  logic              ent_out_ready,
    output logic [TAG_W-1:0]  ent_out_tag,
    output logic [DATA_W-1:0] ent_out_data,
    output logic              ent_err,
    input  logic              it_in_valid,
    output logic              it_in_ready,
    input  logic [TAG_W-1:0]  it_in_tag,
    input  logic [DATA_W-1:0] it_in_data,
    output logic              it_out_valid,
    input  logic              it_out_ready,
    output logic [TAG_W-1:0]  it_out_tag,
    output logic [DATA_W-1:0] it_out_data,
    input  logic              lx_in_valid,
    output logic              lx_in_ready,
    input  logic [TAG_W-1:0]  lx_in_tag,
    input  logic [DATA_W-1:0] lx_in_data,
    output logic              lx_out_valid,
    input  logic              lx_out_ready,
    output logic [TAG_W-1:0]  lx_out_tag,
    output logic [DATA_W-1:0] lx_out_data,
    output logic              note_valid,
    output logic [ACT_W-1:0]  note_outer_act,
    output logic [ACT_W-1:0]  note_freed_act
);
    localparam int TOK_W = TAG_W + DATA_W;

    tag_t ent_t, it_t, lx_t;
    assign ent_t = tag_t'(ent_in_tag);
    assign it_t  = tag_t'(it_in_tag);
    assign lx_t  = tag_t'(lx_in_tag);

    logic             ent_free, it_free, lx_free;
    logic             pool_avail;
    logic [ACT_W-1:0] pool_id;
    tag_t             saved_ent, saved_lx;

    // region path
    logic ent_open, ent_full, ent_fire, ent_rel;
    tag_t ent_next;
    assign ent_open     = region_op_e'(ent_in_kind) == K_OPEN;
    assign ent_full     = nest_full(ent_t);
    assign ent_in_ready = ent_free && (!ent_open || (pool_avail && !ent_full));
    assign ent_fire     = ent_in_valid && ent_in_ready;
    assign ent_rel      = ent_fire && !ent_open && (ent_t.act != '0);
    assign ent_err      = ent_in_valid && ent_open && ent_full;

    always_comb begin
        if (ent_open)               ent_next = open_ctx(ent_t, pool_id);
        else if (ent_t.act == '0)   ent_next = ent_t;
        else                        ent_next = saved_ent;
    end

    // iteration path
    logic it_fire;
    assign it_in_ready = it_free;
    assign it_fire     = it_in_valid && it_in_ready;

    // loop-exit path
    logic lx_fire, lx_rel;
    tag_t lx_next;
    assign lx_in_ready = lx_free;
    assign lx_fire     = lx_in_valid && lx_in_ready;
    assign lx_rel      = lx_fire && (lx_t.act != '0);
    assign lx_next     = (lx_t.act == '0) ? lx_t : saved_lx;

    always_ff @(posedge clk) begin
        if (rst) begin
            note_valid     <= 1'b0;
            note_outer_act <= '0;
            note_freed_act <= '0;
        end else begin
            note_valid <= lx_rel;
            if (lx_rel) begin
                note_outer_act <= saved_lx.act;
                note_freed_act <= lx_t.act;
            end
        end
    end

    ctx_free_pool u_pool (
        .clk      (clk),
        .rst      (rst),
        .alloc    (ent_fire && ent_open),
        .save_tag (ent_t),
        .avail    (pool_avail),
        .alloc_id (pool_id),
        .rel_a    (ent_rel),
        .rel_a_id (ent_t.act),
        .saved_a  (saved_ent),
        .rel_b    (lx_rel),
        .rel_b_id (lx_t.act),
        .saved_b  (saved_lx)
    );

    ctx_out_reg #(.W(TOK_W)) u_ent_reg (
        .clk       (clk),
        .rst       (rst),
        .load      (ent_fire),
        .d         ({ent_next, ent_in_data}),
        .out_ready (ent_out_ready),
        .out_valid (ent_out_valid),
        .q         ({ent_out_tag, ent_out_data}),
        .can_load  (ent_free)
    );

    ctx_out_reg #(.W(TOK_W)) u_it_reg (
        .clk       (clk),
        .rst       (rst),
        .load      (it_fire),
        .d         ({step_iter(it_t), it_in_data}),
        .out_ready (it_out_ready),
        .out_valid (it_out_valid),
        .q         ({it_out_tag, it_out_data}),
        .can_load  (it_free)
    );

    ctx_out_reg #(.W(TOK_W)) u_lx_reg (
        .clk       (clk),
        .rst       (rst),
        .load      (lx_fire),
        .d         ({lx_next, lx_in_data}),
        .out_ready (lx_out_ready),
        .out_valid (lx_out_valid),
        .q         ({lx_out_tag, lx_out_data}),
        .can_load  (lx_free)
    );
endmodule

// File: rtl/ctx_tag_unit_chk.sv
module ctx_tag_unit_chk
    import ctx_tag_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ent_in_valid,
    input logic              ent_in_ready,
    input logic              ent_in_kind,
    input logic [TAG_W-1:0]  ent_in_tag,
    input logic              ent_out_valid,
    input logic              ent_out_ready,
    input logic [TAG_W-1:0]  ent_out_tag,
    input logic [DATA_W-1:0] ent_out_data,
    input logic              ent_err,
    input logic              it_in_valid,
    input logic              it_in_ready,
    input logic [TAG_W-1:0]  it_in_tag,
    input logic              it_out_valid,
    input logic              it_out_ready,
    input logic [TAG_W-1:0]  it_out_tag,
    input logic              lx_in_valid,
    input logic              lx_in_ready,
    input logic [TAG_W-1:0]  lx_in_tag,
    input logic [TAG_W-1:0]  lx_out_tag,
    input logic              note_valid
);
    tag_t ei, eo, ii, io, li;
    assign ei = tag_t'(ent_in_tag);
    assign eo = tag_t'(ent_out_tag);
    assign ii = tag_t'(it_in_tag);
    assign io = tag_t'(it_out_tag);
    assign li = tag_t'(lx_in_tag);

    AST_ITER_STEP: assert property (@(posedge clk) disable iff (rst)
        (it_in_valid && it_in_ready) |=> (it_out_valid && io.iter == ITER_W'($past(ii.iter) + 1'b1) && io.act == $past(ii.act))); // R2

    AST_OPEN_FRESH: assert property (@(posedge clk) disable iff (rst)
        (ent_in_valid && ent_in_ready && ent_in_kind == 1'b0) |=> (ent_out_valid && eo.iter == '0 && eo.act != '0 && eo.nest == NEST_W'($past(ei.nest) + 1'b1))); // R3

    AST_DEPTH_STALL: assert property (@(posedge clk) disable iff (rst)
        (ent_in_valid && ent_in_kind == 1'b0 && ei.nest == {NEST_W{1'b1}}) |-> (!ent_in_ready && ent_err)); // R7

    AST_NOTE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (lx_in_valid && lx_in_ready && li.act != '0) |=> note_valid); // R5

    AST_ROOT_PASS: assert property (@(posedge clk) disable iff (rst)
        (lx_in_valid && lx_in_ready && li.act == '0) |=> (lx_out_tag == $past(lx_in_tag) && !note_valid)); // R8

    AST_HOLD_ENT: assert property (@(posedge clk) disable iff (rst)
        (ent_out_valid && !ent_out_ready) |=> (ent_out_valid && $stable(ent_out_tag) && $stable(ent_out_data))); // R9

    AST_HOLD_IT: assert property (@(posedge clk) disable iff (rst)
        (it_out_valid && !it_out_ready) |-> !it_in_ready); // R9
endmodule

bind ctx_tag_unit ctx_tag_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ent_in_valid  (ent_in_valid),
    .ent_in_ready  (ent_in_ready),
    .ent_in_kind   (ent_in_kind),
    .ent_in_tag    (ent_in_tag),
    .ent_out_valid (ent_out_valid),
    .ent_out_ready (ent_out_ready),
    .ent_out_tag   (ent_out_tag),
    .ent_out_data  (ent_out_data),
    .ent_err       (ent_err),
    .it_in_valid   (it_in_valid),
    .it_in_ready   (it_in_ready),
    .it_in_tag     (it_in_tag),
    .it_out_valid  (it_out_valid),
    .it_out_ready  (it_out_ready),
    .it_out_tag    (it_out_tag),
    .lx_in_valid   (lx_in_valid),
    .lx_in_ready   (lx_in_ready),
    .lx_in_tag     (lx_in_tag),
    .lx_out_tag    (lx_out_tag),
    .note_valid    (note_valid)
);

// File: tb/ctx_tag_unit_tb.sv
module ctx_tag_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int TW = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          ent_in_valid = 0, ent_in_kind = 0, ent_out_ready = 1;
    logic [TW-1:0] ent_in_tag = '0;
    logic [DW-1:0] ent_in_data = '0;
    logic          ent_in_ready, ent_out_valid, ent_err;
    logic [TW-1:0] ent_out_tag;
    logic [DW-1:0] ent_out_data;
    logic          it_in_valid = 0, it_out_ready = 1;
    logic [TW-1:0] it_in_tag = '0;
    logic [DW-1:0] it_in_data = '0;
    logic          it_in_ready, it_out_valid;
    logic [TW-1:0] it_out_tag;
    logic [DW-1:0] it_out_data;
    logic          lx_in_valid = 0, lx_out_ready = 1;
    logic [TW-1:0] lx_in_tag = '0;
    logic [DW-1:0] lx_in_data = '0;
    logic          lx_in_ready, lx_out_valid;
    logic [TW-1:0] lx_out_tag;
    logic [DW-1:0] lx_out_data;
    logic          note_valid;
    logic [2:0]    note_outer_act, note_freed_act;

    ctx_tag_unit #(.DATA_W(DW)) u_dut (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic logic [TW-1:0] mk(int a, int n, int i);
        return {3'(a), 2'(n), 4'(i)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ent_send(logic kind, logic [TW-1:0] t, logic [DW-1:0] d);
        @(negedge clk);
        ent_in_valid = 1; ent_in_kind = kind; ent_in_tag = t; ent_in_data = d;
        @(posedge clk);
        @(negedge clk);
        ent_in_valid = 0;
    endtask

    task automatic it_send(logic [TW-1:0] t, logic [DW-1:0] d);
        @(negedge clk);
        it_in_valid = 1; it_in_tag = t; it_in_data = d;
        @(posedge clk);
        @(negedge clk);
        it_in_valid = 0;
    endtask

    task automatic lx_send(logic [TW-1:0] t, logic [DW-1:0] d);
        @(negedge clk);
        lx_in_valid = 1; lx_in_tag = t; lx_in_data = d;
        @(posedge clk);
        @(negedge clk);
        lx_in_valid = 0;
    endtask

    // {input tag, data, expected tag}
    localparam logic [TW+DW+TW-1:0] IT_VEC [5] = '{
        {9'b000_00_0000, 16'h1234, 9'b000_00_0001},
        {9'b011_10_0111, 16'hBEEF, 9'b011_10_1000},
        {9'b111_11_1111, 16'h0001, 9'b111_11_0000},
        {9'b101_01_1110, 16'hFFFF, 9'b101_01_1111},
        {9'b010_00_1001, 16'h0000, 9'b010_00_1010}
    };

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check("R1 ent_out_valid", ent_out_valid, 0);
        check("R1 it_out_valid", it_out_valid, 0);
        check("R1 lx_out_valid", lx_out_valid, 0);
        check("R1 note_valid", note_valid, 0);
        check("R1 ent_in_ready", ent_in_ready, 1);

        // R2: iteration vectors
        foreach (IT_VEC[k]) begin
            it_send(IT_VEC[k][TW+DW+TW-1 -: TW], IT_VEC[k][TW+DW-1 -: DW]);
            check("R2 valid", it_out_valid, 1);
            check("R2 tag", it_out_tag, IT_VEC[k][TW-1:0]);
            check("R2 data", it_out_data, IT_VEC[k][TW+DW-1 -: DW]);
        end

        // R3: open from root
        ent_send(0, mk(0, 0, 5), 16'h0011);
        check("R3 valid", ent_out_valid, 1);
        check("R3 tag", ent_out_tag, mk(1, 1, 0));
        check("R3 data", ent_out_data, 16'h0011);
        ent_send(0, mk(1, 1, 0), 16'h0022);
        check("R3 nested tag", ent_out_tag, mk(2, 2, 0));

        // R5: loop exit restores and notifies
        lx_send(mk(2, 2, 7), 16'h0033);
        check("R5 valid", lx_out_valid, 1);
        check("R5 tag", lx_out_tag, mk(1, 1, 0));
        check("R5 data", lx_out_data, 16'h0033);
        check("R5 note", note_valid, 1);
        check("R5 outer", note_outer_act, 1);
        check("R5 freed", note_freed_act, 2);
        @(negedge clk);
        check("R5 note one cycle", note_valid, 0);

        // R10: freed id reused
        ent_send(0, mk(1, 1, 3), 16'h0044);
        check("R10 reuse", ent_out_tag, mk(2, 2, 0));

        // R4: region close restores root tag
        ent_send(1, mk(1, 1, 9), 16'h0055);
        check("R4 tag", ent_out_tag, mk(0, 0, 5));
        check("R4 data", ent_out_data, 16'h0055);
        ent_send(0, mk(0, 0, 1), 16'h0066);
        check("R4 id returned", ent_out_tag, mk(1, 1, 0));
        // busy now {1,2}

        // R7: depth saturation
        @(negedge clk);
        ent_in_valid = 1; ent_in_kind = 0; ent_in_tag = mk(2, 3, 0);
        #1;
        check("R7 ready low", ent_in_ready, 0);
        check("R7 err", ent_err, 1);
        @(negedge clk);
        check("R7 no output", ent_out_valid, 0);
        ent_in_valid = 0;
        #1;
        check("R7 err clears", ent_err, 0);

        // R6: drain pool (ids 3..7)
        for (int k = 3; k < 8; k++) begin
            ent_send(0, mk(0, 0, 0), 16'(k));
            check("R6 drain id", ent_out_tag, mk(k, 1, 0));
        end
        @(negedge clk);
        ent_in_valid = 1; ent_in_kind = 0; ent_in_tag = mk(0, 0, 0);
        #1;
        check("R6 ready low when empty", ent_in_ready, 0);
        check("R6 no err", ent_err, 0);
        @(negedge clk);
        check("R6 no output", ent_out_valid, 0);
        ent_in_valid = 0;
        lx_send(mk(4, 1, 2), 16'h0077);
        check("R6 restore", lx_out_tag, mk(0, 0, 0));
        #1;
        ent_in_valid = 1; ent_in_kind = 0; ent_in_tag = mk(0, 0, 0);
        #1;
        check("R6 ready back", ent_in_ready, 1);
        @(posedge clk);
        @(negedge clk);
        ent_in_valid = 0;
        check("R6 R10 id 4", ent_out_tag, mk(4, 1, 0));

        // R8: root passes through
        lx_send(mk(0, 2, 6), 16'h0088);
        check("R8 lx tag", lx_out_tag, mk(0, 2, 6));
        check("R8 no note", note_valid, 0);
        ent_send(1, mk(0, 1, 3), 16'h0099);
        check("R8 close tag", ent_out_tag, mk(0, 1, 3));
        @(negedge clk);
        ent_in_valid = 1; ent_in_kind = 0; ent_in_tag = mk(0, 0, 0);
        #1;
        check("R8 pool still full", ent_in_ready, 0);
        ent_in_valid = 0;

        // R9: backpressure
        it_out_ready = 0;
        it_send(mk(1, 0, 2), 16'hA5A5);
        check("R9 valid", it_out_valid, 1);
        it_in_valid = 1; it_in_tag = mk(2, 0, 0); it_in_data = 16'h5A5A;
        #1;
        check("R9 in_ready low", it_in_ready, 0);
        @(negedge clk);
        check("R9 hold tag", it_out_tag, mk(1, 0, 3));
        check("R9 hold data", it_out_data, 16'hA5A5);
        it_out_ready = 1;
        @(negedge clk);
        check("R9 next accepted", it_out_tag, mk(2, 0, 1));
        it_in_valid = 0;
        @(negedge clk);
        check("R9 drained", it_out_valid, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule